// File: doc/BRIEF.md
# Clear-on-read masked interrupt controller

This block collects single-cycle event pulses from peripheral logic into two 8-bit status registers. Each status register has a matching 8-bit enable register. The block drives one active-low interrupt request line, `irq_no`. That line is low while any status bit whose enable bit is 1 is set.

Events whose enable bit is 0 still latch and stay visible to the host, but they never pull the request line low. The host reads a status register through a simple synchronous register port. The read returns the current contents and, on the same clock edge, clears only the bits that are enabled. The request line then releases until a new enabled event arrives.

Read data is combinational from `addr_i` and does not depend on `rd_i`. The clear and the write take effect on the rising edge where `rd_i` or `wr_i` is high.

Top module: `evt_irq_ctrl`

## Requirements
- R1: Reset state:
  - status A (address 03h) reads 00h;
  - status B (address 04h) reads 01h, because its bit 0 (power-on event) is set at reset;
  - enable A (05h) reads 00h and enable B (06h) reads 01h;
  - so `irq_no` is low straight after reset.
- R2: An event pulse on a valid bit sets that status bit at the next rising edge, whatever its enable bit is. The set bit stays visible on reads.
  - Status A valid bits: 7 FIFO error, 6 TX almost full, 5 TX almost empty, 3 external event, 2 packet sent.
  - Status B valid bits: 3 wake timer, 2 low battery, 1 chip ready, 0 power-on.
  - `evt_i[7:0]` feeds status A and `evt_i[15:8]` feeds status B.
- R3: `irq_no` is 0 whenever some status bit and its enable bit are both 1. It is 1 when there is no such bit.
- R4: A status bit whose enable bit is 0 never drives `irq_no` low.
- R5: A status read (`rd_i` high at 03h or 04h) returns the value held before the edge. At that edge it clears the bits that are enabled and keeps the bits that are not enabled.
- R6: Once low, `irq_no` stays low until the host reads the status register that holds the enabled bit. It goes high after that read if no other enabled bit is pending.
- R7: An event pulse in the same cycle as a clearing read of its bit leaves the bit set.
- R8: The enable registers are read/write at 05h (A) and 06h (B) and use the same bit positions as status.
  - Reserved bits always read 0 and ignore writes: A bits 4, 1, 0 and B bits 7..4, in both status and enable registers.
  - Events on reserved bits are dropped.
- R9: Writes to 03h and 04h change nothing. Reads from any address other than 03h..06h return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 16 | Event pulses: [7:0] status A, [15:8] status B |
| addr_i | input | 8 | Register address |
| rd_i | input | 1 | Read strobe (clears enabled status bits at the edge) |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The hardest case to reach is an event arriving in the very cycle a read clears its bit. The bench holds the event pulse and the status read strobe in the same cycle and checks that the bit and the request both survive. A second read then clears them.

The bench also builds status contents that mix enabled and disabled bits. It does this by latching events while their enables are 0 and then changing the enables. It checks that a read removes only the enabled part and that the request follows it.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int W     = 8;
  localparam int NBANK = 2;
  localparam int AW    = 8;
  localparam logic [NBANK-1:0][W-1:0] VALID_MASK = {8'h0F, 8'hEC};
  localparam logic [NBANK-1:0][W-1:0] STAT_RST   = {8'h01, 8'h00};
  localparam logic [NBANK-1:0][W-1:0] EN_RST     = {8'h01, 8'h00};
  localparam logic [AW-1:0] STAT_BASE = 8'h03;
  localparam logic [AW-1:0] EN_BASE   = 8'h05;
endpackage

// File: rtl/evt_stat_bank.sv
module evt_stat_bank #(
  parameter int          W     = 8,
  parameter logic [W-1:0] VALID = '1,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] en_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q, clr_mask;

  assign clr_mask = clr_i ? en_i : '0;

  // new events win over the clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= RST & VALID;
    else         stat_q <= ((stat_q & ~clr_mask) | evt_i) & VALID;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/evt_en_bank.sv
module evt_en_bank #(
  parameter int          W     = 8,
  parameter logic [W-1:0] VALID = '1,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= RST & VALID;
    else if (we_i) en_q <= wdata_i & VALID;
  end

  assign en_o = en_q;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NBANK*W-1:0]  evt_i,
  input  logic [AW-1:0]       addr_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [W-1:0]        wdata_i,
  output logic [W-1:0]        rdata_o,
  output logic                irq_no
);
  logic [NBANK-1:0][W-1:0] stat_q, en_q;
  logic [NBANK-1:0]        stat_hit, en_hit, pend;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign stat_hit[b] = (addr_i == STAT_BASE + AW'(b));
    assign en_hit[b]   = (addr_i == EN_BASE + AW'(b));
    assign pend[b]     = |(stat_q[b] & en_q[b]);

    evt_stat_bank #(.W(W), .VALID(VALID_MASK[b]), .RST(STAT_RST[b])) u_stat (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt_i[b*W +: W]),
      .en_i   (en_q[b]),
      .clr_i  (rd_i & stat_hit[b]),
      .stat_o (stat_q[b])
    );

    evt_en_bank #(.W(W), .VALID(VALID_MASK[b]), .RST(EN_RST[b])) u_en (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_i & en_hit[b]),
      .wdata_i (wdata_i),
      .en_o    (en_q[b])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (stat_hit[b]) rdata_o = stat_q[b];
      if (en_hit[b])   rdata_o = en_q[b];
    end
  end

  assign irq_no = ~|pend;
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
  import evt_irq_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NBANK*W-1:0]  evt_i,
  input logic [AW-1:0]       addr_i,
  input logic                rd_i,
  input logic                wr_i,
  input logic [W-1:0]        rdata_o,
  input logic                irq_no,
  input logic [NBANK*W-1:0]  stat_q,
  input logic [NBANK*W-1:0]  en_q
);
  logic stat_rd, mapped;
  assign stat_rd = rd_i && (addr_i == STAT_BASE || addr_i == STAT_BASE + 8'd1);
  assign mapped  = addr_i >= STAT_BASE && addr_i <= EN_BASE + 8'd1;

  // R9
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> rdata_o == '0);

  // R8
  resv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == STAT_BASE || addr_i == EN_BASE) |-> (rdata_o & ~VALID_MASK[0]) == '0);

  // R6
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && !stat_rd && !wr_i) |=> !irq_no);

  // R5
  keep_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (stat_q & $past(stat_q & ~en_q)) == $past(stat_q & ~en_q));

  // R2
  evt_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (stat_q & $past(evt_i & VALID_MASK)) == $past(evt_i & VALID_MASK));
endmodule

bind evt_irq_ctrl evt_irq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .evt_i   (evt_i),
  .addr_i  (addr_i),
  .rd_i    (rd_i),
  .wr_i    (wr_i),
  .rdata_o (rdata_o),
  .irq_no  (irq_no),
  .stat_q  (stat_q),
  .en_q    (en_q)
);

// File: tb/evt_irq_ctrl_tb.sv
module evt_irq_ctrl_tb;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic [15:0] evt_i = '0;
  logic [7:0]  addr_i = '0;
  logic        rd_i = 0, wr_i = 0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        irq_no;
  int total = 0, bad = 0;

  evt_irq_ctrl u_dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic peek(logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i); addr_i = a; #1 d = rdata_o;
  endtask

  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1;
    @(negedge clk_i); wr_i = 0;
  endtask

  task automatic rd_reg(logic [7:0] a, logic [15:0] ev, output logic [7:0] d);
    @(negedge clk_i); addr_i = a; rd_i = 1; evt_i = ev; #1 d = rdata_o;
    @(negedge clk_i); rd_i = 0; evt_i = '0;
  endtask

  task automatic pulse(logic [15:0] ev);
    @(negedge clk_i); evt_i = ev;
    @(negedge clk_i); evt_i = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq", {7'd0, irq_no}, 8'h00);
    peek(8'h03, d); chk("R1 statA", d, 8'h00);
    peek(8'h04, d); chk("R1 statB", d, 8'h01);
    peek(8'h05, d); chk("R1 enA", d, 8'h00);
    peek(8'h06, d); chk("R1 enB", d, 8'h01);
    rd_reg(8'h04, 16'h0, d); chk("R5 rd statB", d, 8'h01);
    #1 chk("R6 irq released", {7'd0, irq_no}, 8'h01);
    peek(8'h04, d); chk("R5 statB cleared", d, 8'h00);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    pulse(16'h00FF);
    peek(8'h03, d); chk("R2/R8 statA latch", d, 8'hEC);
    chk("R4 irq off", {7'd0, irq_no}, 8'h01);
    rd_reg(8'h03, 16'h0, d); chk("R5 rd statA", d, 8'hEC);
    peek(8'h03, d); chk("R5 disabled kept", d, 8'hEC);
  endtask

  task automatic t_enable();
    logic [7:0] d;
    wr_reg(8'h05, 8'hFF);
    peek(8'h05, d); chk("R8 enA resv", d, 8'hEC);
    #1 chk("R3 irq low", {7'd0, irq_no}, 8'h00);
    rd_reg(8'h03, 16'h0, d); chk("R5 rd statA", d, 8'hEC);
    peek(8'h03, d); chk("R5 statA clr", d, 8'h00);
    chk("R6 irq high", {7'd0, irq_no}, 8'h01);
    wr_reg(8'h05, 8'h04);
    pulse(16'h0024);
    repeat (3) @(negedge clk_i);
    #1 chk("R6 irq held", {7'd0, irq_no}, 8'h00);
    rd_reg(8'h03, 16'h0, d); chk("R5 rd partial", d, 8'h24);
    peek(8'h03, d); chk("R5 partial kept", d, 8'h20);
    chk("R4 irq high w/ disabled", {7'd0, irq_no}, 8'h01);
    wr_reg(8'h05, 8'hEC);
    rd_reg(8'h03, 16'h0, d);
    peek(8'h03, d); chk("R5 statA empty", d, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    wr_reg(8'h06, 8'h0F);
    peek(8'h06, d); chk("R8 enB", d, 8'h0F);
    pulse(16'h0200);
    rd_reg(8'h04, 16'h0200, d); chk("R7 rd pre-clear", d, 8'h02);
    peek(8'h04, d); chk("R7 bit kept", d, 8'h02);
    chk("R7 irq low", {7'd0, irq_no}, 8'h00);
    rd_reg(8'h04, 16'h0, d);
    peek(8'h04, d); chk("R5 statB clr", d, 8'h00);
    chk("R6 irq high", {7'd0, irq_no}, 8'h01);
  endtask

  task automatic t_ignore();
    logic [7:0] d;
    wr_reg(8'h03, 8'hFF);
    wr_reg(8'h04, 8'hFF);
    peek(8'h03, d); chk("R9 statA wr", d, 8'h00);
    peek(8'h04, d); chk("R9 statB wr", d, 8'h00);
    chk("R9 irq", {7'd0, irq_no}, 8'h01);
    peek(8'h00, d); chk("R9 addr00", d, 8'h00);
    peek(8'h07, d); chk("R9 addr07", d, 8'h00);
    peek(8'hFF, d); chk("R9 addrFF", d, 8'h00);
    wr_reg(8'h06, 8'hF0);
    peek(8'h06, d); chk("R8 enB resv", d, 8'h00);
    pulse(16'hF000);
    peek(8'h04, d); chk("R8 resv evt", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_disabled();
    t_enable();
    t_collide();
    t_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule